// File: doc/BRIEF.md
# Bit-Count and Packed-Lane Arithmetic Unit

This block is a 64-bit execution unit for integer operations that work on bit counts and on packed lanes inside one register. It counts set bits, leading zeros and trailing zeros. It sums absolute byte differences and widens or narrows bytes between packed and spread layouts. It sign-extends the low byte or halfword, and it takes a lane-wise minimum or maximum over eight bytes or four 16-bit words, either signed or unsigned.

An issue stage presents two operands, a 7-bit function code and a valid strobe. One clock later the unit returns the result together with a valid strobe that follows the input strobe. Any function code outside the supported set raises an illegal flag and returns zero. Results narrower than the datapath are zero-extended. While no operation is issued, the result and the flag read as zero.

Top module: `bitpack_unit`

## Requirements
- R1: Code 0x00 returns op_b[7:0] sign-extended to 64 bits, and code 0x01 returns op_b[15:0] sign-extended to 64 bits.
- R2: Code 0x30 returns the number of set bits in op_b.
- R3: Code 0x32 returns the number of zero bits above the highest set bit of op_b, and returns 64 when op_b is zero.
- R4: Code 0x33 returns the number of zero bits below the lowest set bit of op_b, and returns 64 when op_b is zero.
- R5: Code 0x31 returns the sum over all eight byte lanes of |a_byte - b_byte|, with both bytes taken as unsigned.
- R6: Code 0x34 places op_b bytes 0, 1, 2 and 3 at result bits 0, 16, 32 and 48. Code 0x35 places op_b bytes 0 and 1 at result bits 0 and 32. Every other result bit is zero.
- R7: Code 0x36 packs the op_b bytes found at bits 0, 16, 32 and 48 into result bytes 0 to 3. Code 0x37 packs the bytes at bits 0 and 32 into result bytes 0 and 1. Every other result bit is zero.
- R8: Codes 0x38 to 0x3f select per lane, and each lane is chosen independently of the others. The codes are: 0x38 min signed byte, 0x39 min signed word, 0x3a min unsigned byte, 0x3b min unsigned word, 0x3c max unsigned byte, 0x3d max unsigned word, 0x3e max signed byte, 0x3f max signed word. A byte lane is 8 bits and a word lane is 16 bits. When the two lanes are equal, the op_b lane is returned.
- R9: Any other code sets illegal and returns a zero result. Every listed code leaves illegal clear.
- R10: A request applied with in_valid high at a clock edge appears on result, illegal and out_valid after that edge. out_valid equals in_valid from the previous edge. When out_valid is low, result and illegal are zero. Synchronous reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| func | input | 7 | Function code |
| op_a | input | 64 | First operand (used by difference and min/max) |
| op_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Registered result |
| illegal | output | 1 | Unsupported function code |

## Verification
The checker assumes that func, op_a and op_b are known, stable values whenever in_valid is high at an edge. Its past-value properties read those inputs one cycle back through $past. The stimulus meets this assumption by changing inputs only on the falling edge and by always driving fully defined random or directed operands. It draws codes mostly from the supported set and now and then from the whole 7-bit space, so the illegal path is also covered. Idle cycles with in_valid low are mixed in, so the zeroed-output behaviour is exercised as well as the issue path.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;
  localparam logic [6:0] FN_SEXT_B  = 7'h00;
  localparam logic [6:0] FN_SEXT_H  = 7'h01;
  localparam logic [6:0] FN_POPCNT  = 7'h30;
  localparam logic [6:0] FN_ABSDIFF = 7'h31;
  localparam logic [6:0] FN_LZCNT   = 7'h32;
  localparam logic [6:0] FN_TZCNT   = 7'h33;
  localparam logic [6:0] FN_SPREAD2 = 7'h34;
  localparam logic [6:0] FN_SPREAD4 = 7'h35;
  localparam logic [6:0] FN_GATHER2 = 7'h36;
  localparam logic [6:0] FN_GATHER4 = 7'h37;
  // min/max group occupies 0x38..0x3f
  localparam logic [3:0] FN_MM_PREFIX = 4'b0111;

  typedef struct packed {
    logic is_max;
    logic is_signed;
    logic wide;
  } mm_ctl_t;

  function automatic mm_ctl_t mm_decode(input logic [6:0] f);
    mm_ctl_t c;
    c.is_max    = f[2];
    c.is_signed = ~(f[2] ^ f[1]);
    c.wide      = f[0];
    return c;
  endfunction
endpackage

// File: rtl/bitpack_count.sv
module bitpack_count #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] val,
  output logic [CNT_W-1:0]  pop,
  output logic [CNT_W-1:0]  lead,
  output logic [CNT_W-1:0]  trail
);
  always_comb begin
    pop = '0;
    for (int i = 0; i < DATA_W; i++) begin
      pop = pop + CNT_W'(val[i]);
    end
  end

  // highest set bit wins because it is visited last
  always_comb begin
    lead = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (val[i]) lead = CNT_W'(DATA_W - 1 - i);
    end
  end

  // lowest set bit wins because it is visited last
  always_comb begin
    trail = CNT_W'(DATA_W);
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (val[i]) trail = CNT_W'(i);
    end
  end
endmodule

// File: rtl/bitpack_lanes.sv
module bitpack_lanes #(
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8,
  localparam int SAD_W = 8 + $clog2(NB)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [SAD_W-1:0]  sad,
  output logic [DATA_W-1:0] spread2,
  output logic [DATA_W-1:0] spread4,
  output logic [DATA_W-1:0] gather2,
  output logic [DATA_W-1:0] gather4,
  output logic [DATA_W-1:0] sext_b,
  output logic [DATA_W-1:0] sext_h
);
  logic [7:0] diff [NB];

  for (genvar i = 0; i < NB; i++) begin : g_diff
    logic [7:0] ab, bb;
    assign ab = a[8*i +: 8];
    assign bb = b[8*i +: 8];
    assign diff[i] = (ab >= bb) ? (ab - bb) : (bb - ab);
  end

  always_comb begin
    sad = '0;
    for (int i = 0; i < NB; i++) begin
      sad = sad + SAD_W'(diff[i]);
    end
  end

  for (genvar i = 0; i < NB / 2; i++) begin : g_half
    assign spread2[16*i +: 16] = {8'h00, b[8*i +: 8]};
    assign gather2[8*i +: 8]   = b[16*i +: 8];
  end
  assign gather2[DATA_W-1:DATA_W/2] = '0;

  for (genvar i = 0; i < NB / 4; i++) begin : g_quarter
    assign spread4[32*i +: 32] = {24'h000000, b[8*i +: 8]};
    assign gather4[8*i +: 8]   = b[32*i +: 8];
  end
  assign gather4[DATA_W-1:DATA_W/4] = '0;

  assign sext_b = {{(DATA_W-8){b[7]}}, b[7:0]};
  assign sext_h = {{(DATA_W-16){b[15]}}, b[15:0]};
endmodule

// File: rtl/bitpack_minmax.sv
module bitpack_minmax #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int NL    = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  input  logic              is_max,
  output logic [DATA_W-1:0] y
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    logic a_lt, a_gt, take_a;
    assign la = a[LANE_W*i +: LANE_W];
    assign lb = b[LANE_W*i +: LANE_W];
    always_comb begin
      if (is_signed) begin
        a_lt = $signed(la) < $signed(lb);
        a_gt = $signed(la) > $signed(lb);
      end else begin
        a_lt = la < lb;
        a_gt = la > lb;
      end
      // strict compare: ties fall through to the b lane
      take_a = is_max ? a_gt : a_lt;
    end
    assign y[LANE_W*i +: LANE_W] = take_a ? la : lb;
  end
endmodule

// File: rtl/bitpack_unit.sv
module bitpack_unit
  import bitpack_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FUNC_W-1:0] func,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam int SAD_W = 8 + $clog2(DATA_W / 8);

  logic [CNT_W-1:0]  pop, lead, trail;
  logic [SAD_W-1:0]  sad;
  logic [DATA_W-1:0] spread2, spread4, gather2, gather4, sext_b, sext_h;
  logic [DATA_W-1:0] mm_byte, mm_word;
  mm_ctl_t           mm;
  logic [DATA_W-1:0] nxt;
  logic              legal;

  assign mm = mm_decode(func[6:0]);

  bitpack_count #(.DATA_W(DATA_W)) u_count (
    .val(op_b), .pop(pop), .lead(lead), .trail(trail)
  );

  bitpack_lanes #(.DATA_W(DATA_W)) u_lanes (
    .a(op_a), .b(op_b), .sad(sad),
    .spread2(spread2), .spread4(spread4),
    .gather2(gather2), .gather4(gather4),
    .sext_b(sext_b), .sext_h(sext_h)
  );

  bitpack_minmax #(.DATA_W(DATA_W), .LANE_W(8)) u_mm_byte (
    .a(op_a), .b(op_b), .is_signed(mm.is_signed), .is_max(mm.is_max), .y(mm_byte)
  );

  bitpack_minmax #(.DATA_W(DATA_W), .LANE_W(16)) u_mm_word (
    .a(op_a), .b(op_b), .is_signed(mm.is_signed), .is_max(mm.is_max), .y(mm_word)
  );

  always_comb begin
    nxt   = '0;
    legal = 1'b1;
    if (func[6:3] == FN_MM_PREFIX) begin
      nxt = mm.wide ? mm_word : mm_byte;
    end else begin
      case (func[6:0])
        FN_SEXT_B:  nxt = sext_b;
        FN_SEXT_H:  nxt = sext_h;
        FN_POPCNT:  nxt = {{(DATA_W-CNT_W){1'b0}}, pop};
        FN_ABSDIFF: nxt = {{(DATA_W-SAD_W){1'b0}}, sad};
        FN_LZCNT:   nxt = {{(DATA_W-CNT_W){1'b0}}, lead};
        FN_TZCNT:   nxt = {{(DATA_W-CNT_W){1'b0}}, trail};
        FN_SPREAD2: nxt = spread2;
        FN_SPREAD4: nxt = spread4;
        FN_GATHER2: nxt = gather2;
        FN_GATHER4: nxt = gather4;
        default:    legal = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      result    <= in_valid ? nxt : '0;
      illegal   <= in_valid & ~legal;
    end
  end
endmodule

// File: rtl/bitpack_unit_chk.sv
module bitpack_unit_chk #(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [FUNC_W-1:0] func,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);
  p_issue_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (result == '0 && !illegal));
  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> result == '0);
  p_sext_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == 7'h00) |=>
      (result[7:0] == $past(op_b[7:0]) &&
       (result[DATA_W-1:7] == '0 || &result[DATA_W-1:7])));
  p_pop_range_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == 7'h30) |=> (result <= DATA_W && !illegal));
  p_lz_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == 7'h32 && op_b == '0) |=> result == DATA_W);
  p_tz_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == 7'h33 && op_b == '0) |=> result == DATA_W);
  p_gather_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == 7'h37) |=> result[DATA_W-1:16] == '0);
  p_min_ub_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == 7'h3a) |=>
      (result[7:0] <= $past(op_a[7:0]) && result[7:0] <= $past(op_b[7:0])));
endmodule

bind bitpack_unit bitpack_unit_chk #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
  .result(result), .illegal(illegal)
);

// File: tb/sim_bitpack_unit.sv
module sim_bitpack_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  func = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        out_valid, illegal;
  logic [63:0] result;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  bitpack_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  function automatic string tag(input logic [6:0] f);
    case (f)
      7'h00, 7'h01: return "R1";
      7'h30: return "R2";
      7'h32: return "R3";
      7'h33: return "R4";
      7'h31: return "R5";
      7'h34, 7'h35: return "R6";
      7'h36, 7'h37: return "R7";
      default: return (f[6:3] == 4'b0111) ? "R8" : "R9";
    endcase
  endfunction

  function automatic logic [63:0] ref_op(input logic [6:0] f, input logic [63:0] a,
                                         input logic [63:0] b, output logic ill);
    logic [63:0] r = '0;
    int n;
    ill = 1'b0;
    case (f)
      7'h00: r = {{56{b[7]}}, b[7:0]};
      7'h01: r = {{48{b[15]}}, b[15:0]};
      7'h30: r = 64'($countones(b));
      7'h32: begin n = 0; while (n < 64 && !b[63-n]) n++; r = 64'(n); end
      7'h33: begin n = 0; while (n < 64 && !b[n]) n++; r = 64'(n); end
      7'h31: begin
        n = 0;
        for (int i = 0; i < 8; i++) begin
          int x = int'(a[8*i +: 8]);
          int y = int'(b[8*i +: 8]);
          n += (x > y) ? x - y : y - x;
        end
        r = 64'(n);
      end
      7'h34: r = {8'h0, b[31:24], 8'h0, b[23:16], 8'h0, b[15:8], 8'h0, b[7:0]};
      7'h35: r = {24'h0, b[15:8], 24'h0, b[7:0]};
      7'h36: r = {32'h0, b[55:48], b[39:32], b[23:16], b[7:0]};
      7'h37: r = {48'h0, b[39:32], b[7:0]};
      default: begin
        if (f[6:3] == 4'b0111) begin
          int  lw  = f[0] ? 16 : 8;
          bit  mx  = f[2];
          bit  sg  = (f[2:1] == 2'b11) || (f[2:1] == 2'b00);
          for (int i = 0; i < 64 / lw; i++) begin
            longint ua = longint'((a >> (i*lw)) & ((64'd1 << lw) - 1));
            longint ub = longint'((b >> (i*lw)) & ((64'd1 << lw) - 1));
            longint sa = ua, sb = ub;
            bit pick_a;
            if (sg && sa >= (64'sd1 <<< (lw-1))) sa -= (64'sd1 <<< lw);
            if (sg && sb >= (64'sd1 <<< (lw-1))) sb -= (64'sd1 <<< lw);
            pick_a = mx ? (sa > sb) : (sa < sb);
            r |= 64'(pick_a ? ua : ub) << (i*lw);
          end
        end else begin
          ill = 1'b1;
        end
      end
    endcase
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
    logic ill_e;
    logic [63:0] exp;
    exp = ref_op(f, a, b, ill_e);
    @(negedge clk);
    in_valid = 1'b1; func = f; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "out_valid", 64'(out_valid), 64'd1);
    check(tag(f), $sformatf("result f=%h", f), result, exp);
    check(ill_e ? "R9" : tag(f), "illegal", 64'(illegal), 64'(ill_e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // reset state (R10)
    check("R10", "reset out_valid", 64'(out_valid), 64'd0);
    check("R10", "reset result", result, 64'd0);
    check("R10", "reset illegal", 64'(illegal), 64'd0);
    rst = 1'b0;

    // directed corners
    run_op(7'h00, 64'h0, 64'h1234_5678_9abc_de80);   // R1 negative byte
    run_op(7'h00, 64'h0, 64'hffff_ffff_ffff_ff7f);   // R1 positive byte
    run_op(7'h01, 64'h0, 64'h0000_0000_0000_7fff);   // R1
    run_op(7'h01, 64'h0, 64'h0000_0000_0000_8001);   // R1
    run_op(7'h30, 64'h0, 64'hffff_ffff_ffff_ffff);   // R2 all ones
    run_op(7'h30, 64'h0, 64'h0);                     // R2 zero
    run_op(7'h32, 64'h0, 64'h0);                     // R3 zero -> 64
    run_op(7'h32, 64'h0, 64'h1);                     // R3 -> 63
    run_op(7'h32, 64'h0, 64'h8000_0000_0000_0000);   // R3 -> 0
    run_op(7'h33, 64'h0, 64'h0);                     // R4 zero -> 64
    run_op(7'h33, 64'h0, 64'h8000_0000_0000_0000);   // R4 -> 63
    run_op(7'h33, 64'h0, 64'hffff_ffff_ffff_ffff);   // R4 -> 0
    run_op(7'h31, 64'h0, 64'hffff_ffff_ffff_ffff);   // R5 max sum
    run_op(7'h31, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201); // R5
    run_op(7'h34, 64'h0, 64'h8877_6655_4433_2211);   // R6
    run_op(7'h35, 64'h0, 64'h8877_6655_4433_2211);   // R6
    run_op(7'h36, 64'h0, 64'h8877_6655_4433_2211);   // R7
    run_op(7'h37, 64'h0, 64'h8877_6655_4433_2211);   // R7
    for (int f = 8'h38; f <= 8'h3f; f++) begin       // R8 sign boundaries
      run_op(7'(f), 64'h807f_8000_7fff_0180, 64'h7f80_7fff_8000_0180);
    end
    run_op(7'h02, 64'h5, 64'h5);                     // R9
    run_op(7'h7f, 64'h5, 64'h5);                     // R9
    run_op(7'h2f, 64'h5, 64'h5);                     // R9

    // idle cycle: nothing issued (R10)
    @(negedge clk);
    @(negedge clk);
    check("R10", "idle out_valid", 64'(out_valid), 64'd0);
    check("R10", "idle result", result, 64'd0);
    check("R10", "idle illegal", 64'(illegal), 64'd0);

    // constrained random
    for (int k = 0; k < 600; k++) begin
      logic [6:0] f;
      logic [63:0] a, b;
      int sel = int'($urandom_range(0, 9));
      if (sel == 0) f = 7'($urandom);
      else if (sel < 5) f = 7'h38 + 7'($urandom_range(0, 7));
      else if (sel < 7) f = 7'h30 + 7'($urandom_range(0, 7));
      else f = 7'($urandom_range(0, 1));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) b = b >> $urandom_range(0, 63);
      if ($urandom_range(0, 7) == 0) b = b << $urandom_range(0, 63);
      run_op(f, a, b);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule